// File: doc/BRIEF.md
# Programmable GF(2^m) Inner-Product Unit

This block computes the dot product of two vectors whose elements live in a binary extension field GF(2^m). Both the field order m (1 to 8) and the field polynomial are set at run time through a configuration port, so one instance serves several codes. Operands of narrower fields are zero-extended inside the 8-bit datapath. Bits of an operand or of the polynomial at or above position m are ignored.

Element pairs arrive on a valid/ready stream, one pair per clock, with a flag on the final pair. Each pair is multiplied as a plain carry-less polynomial product, and the 15-bit unreduced products are XOR-summed into an accumulator. After the flagged pair, a digit-serial reduction stage clears `DIGIT` degrees per cycle, from degree 14 down to degree m. It does this by XORing in the full polynomial shifted to each degree whose coefficient is set. The m-bit remainder is then presented with a one-cycle done strobe. The reduction therefore runs once per vector rather than once per product.

Top module: `gf_inner_product`

## Requirements
- R1: After reset, in_ready is 1, res_valid is 0 and res_data is 0. The configuration is then m = 8 with low polynomial coefficients 8'h1D, i.e. p(x) = x^8+x^4+x^3+x^2+1.
- R2: While in_ready is 1, a pair is accepted on every clock with in_valid high, and idle cycles between pairs are allowed. The result equals the XOR over all pairs of the field product a*b mod p(x).
- R3: A vector of one pair yields exactly the reduced field product of that pair.
- R4: Bits at positions m and above of in_a and in_b have no effect on the result.
- R5: cfg_poly bit i (i < m) is the coefficient of x^i, and the x^m term is implied. cfg_poly bits at positions m and above have no effect.
- R6: A configuration write takes effect only when in_ready is 1, no vector is partly received, and in_valid is 0. It is also ignored when cfg_m is 0 or greater than 8. An ignored write leaves the previous configuration in force.
- R7: After the clock edge that accepts the flagged pair, in_ready is 0 until the result appears. res_valid rises exactly ceil((15-m)/DIGIT) edges after that accepting edge, for one cycle only, and in_ready is 1 again in that same cycle.
- R8: res_data has zeros at bit positions m and above. It holds its value until the next result.
- R9: Each new vector starts from an empty accumulator, so earlier vectors do not contribute to its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_m | input | 4 | Field order m (1..8) |
| cfg_poly | input | 8 | Polynomial coefficients x^0..x^(m-1) |
| in_valid | input | 1 | Element pair valid |
| in_ready | output | 1 | Unit can accept a pair |
| in_a | input | 8 | First operand element |
| in_b | input | 8 | Second operand element |
| in_last | input | 1 | Pair is the final one of the vector |
| res_valid | output | 1 | One-cycle done strobe |
| res_data | output | 8 | Reduced inner product, m bits used |

## Verification
The reference model computes each product with a shift-and-conditional-XOR field multiply that reduces at every step. It then XORs those reduced products together. Agreement with it therefore shows that a single late reduction of the unreduced sum gives the same field result. The random vectors use every m from 1 to 8, arbitrary polynomials, lengths 1 to 6, idle bubbles, and operands with junk in their upper bits. These separate correct masking from leakage of stale high bits, and a working accumulator from a lost or double-counted product. The directed cases do three things. A reset-default case checks x * x^7 = p's low part. Configuration writes issued mid-vector, during reduction and out of range show that a write lands only in idle. Latency counts per m confirm the digit-serial schedule.

// File: rtl/gfip_pkg.sv
package gfip_pkg;
    typedef enum logic [0:0] {
        ST_ACC = 1'b0,
        ST_RED = 1'b1
    } state_e;
endpackage

// File: rtl/gfip_clmul.sv
// Carry-less (GF(2) polynomial) product of two W-bit operands, unreduced.
module gfip_clmul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) p = p ^ ((2*W-1)'(a) << i);
        end
    end
endmodule

// File: rtl/gfip_red_slice.sv
// Clears one degree of the remainder by XORing in the shifted polynomial.
module gfip_red_slice #(
    parameter int W     = 8,
    parameter int ACC_W = 15,
    parameter int DW    = 4
) (
    input  logic [ACC_W-1:0] rem_i,
    input  logic             en,
    input  logic [DW-1:0]    shamt,
    input  logic             top_bit,
    input  logic [W:0]       poly_full,
    output logic [ACC_W-1:0] rem_o
);
    always_comb begin
        rem_o = rem_i;
        if (en && top_bit) rem_o = rem_i ^ (ACC_W'(poly_full) << shamt);
    end
endmodule

// File: rtl/gf_inner_product.sv
module gf_inner_product #(
    parameter int               MAX_M    = 8,
    parameter int               DIGIT    = 2,
    parameter logic [MAX_M-1:0] RST_POLY = 8'h1D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_m,
    input  logic [MAX_M-1:0] cfg_poly,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MAX_M-1:0] in_a,
    input  logic [MAX_M-1:0] in_b,
    input  logic             in_last,
    output logic             res_valid,
    output logic [MAX_M-1:0] res_data
);
    import gfip_pkg::*;

    localparam int ACC_W = 2*MAX_M - 1;
    localparam int DW    = $clog2(ACC_W + 1);
    localparam int MW    = 4;

    typedef struct packed {
        state_e           st;
        logic             mid;
        logic [ACC_W-1:0] acc;
        logic [DW-1:0]    deg;
        logic [MW-1:0]    m;
        logic [MAX_M-1:0] poly;
        logic             rv;
        logic [MAX_M-1:0] res;
    } regs_t;

    regs_t q, d;

    logic [MAX_M-1:0] mask;
    logic [MAX_M:0]   poly_full;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] rem [DIGIT+1];
    logic [DIGIT-1:0] sl_en;
    logic [DW-1:0]    sl_deg [DIGIT];

    always_comb begin
        for (int i = 0; i < MAX_M; i++) mask[i] = (i < int'(q.m));
        poly_full = {1'b0, q.poly & mask} | ((MAX_M+1)'(1) << q.m);
    end

    gfip_clmul #(.W(MAX_M)) u_mul (
        .a (in_a & mask),
        .b (in_b & mask),
        .p (prod)
    );

    assign rem[0] = q.acc;

    for (genvar k = 0; k < DIGIT; k++) begin : g_slice
        always_comb begin
            sl_deg[k] = q.deg - DW'(k);
            sl_en[k]  = (q.st == ST_RED) && (int'(q.deg) >= k)
                        && (int'(q.deg) - k >= int'(q.m));
        end
        gfip_red_slice #(.W(MAX_M), .ACC_W(ACC_W), .DW(DW)) u_slice (
            .rem_i     (rem[k]),
            .en        (sl_en[k]),
            .shamt     (sl_deg[k] - DW'(q.m)),
            .top_bit   (rem[k][sl_deg[k]]),
            .poly_full (poly_full),
            .rem_o     (rem[k+1])
        );
        // R7: an enabled slice always leaves its degree cleared
        a_r7_digit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            sl_en[k] |-> (rem[k+1][sl_deg[k]] == 1'b0));
    end

    always_comb begin
        d    = q;
        d.rv = 1'b0;
        case (q.st)
            ST_ACC: begin
                if (in_valid) begin
                    d.acc = q.acc ^ prod;
                    if (in_last) begin
                        d.st  = ST_RED;
                        d.deg = DW'(ACC_W - 1);
                        d.mid = 1'b0;
                    end else begin
                        d.mid = 1'b1;
                    end
                end else if (cfg_we && !q.mid && cfg_m != 4'd0
                             && int'(cfg_m) <= MAX_M) begin
                    d.m    = cfg_m;
                    d.poly = cfg_poly;
                end
            end
            ST_RED: begin
                d.acc = rem[DIGIT];
                if (int'(q.deg) < int'(q.m) + DIGIT) begin
                    d.st  = ST_ACC;
                    d.rv  = 1'b1;
                    d.res = rem[DIGIT][MAX_M-1:0] & mask;
                    d.acc = '0;
                end else begin
                    d.deg = q.deg - DW'(DIGIT);
                end
            end
            default: d.st = ST_ACC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_ACC;
            q.mid  <= 1'b0;
            q.acc  <= '0;
            q.deg  <= '0;
            q.m    <= MW'(MAX_M);
            q.poly <= RST_POLY;
            q.rv   <= 1'b0;
            q.res  <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.st == ST_ACC);
    assign res_valid = q.rv;
    assign res_data  = q.res;

    // R7: accepting the flagged pair drops ready on the next cycle
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);
    // R7: done strobe lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R8: result has no bits at or above m
    a_r8_res_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_data & ~mask) == '0));
    // R6: configuration frozen while busy
    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> ($stable(q.m) && $stable(q.poly)));
    // R9: accumulator is empty when a result is delivered
    a_r9_acc_empty: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (q.acc == '0));
endmodule

// File: tb/tb_gf_inner_product.sv
`timescale 1ns/1ps
module tb_gf_inner_product;
    localparam int DIGIT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_m = '0;
    logic [7:0] cfg_poly = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_a = '0;
    logic [7:0] in_b = '0;
    logic       in_last = 1'b0;
    logic       res_valid;
    logic [7:0] res_data;

    int n_chk = 0;
    int n_fail = 0;
    int cur_m = 8;
    int cur_p = 8'h1D;
    logic [7:0] va [8];
    logic [7:0] vb [8];
    bit finished = 0;

    gf_inner_product #(.DIGIT(DIGIT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_m(cfg_m),
        .cfg_poly(cfg_poly), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_last(in_last),
        .res_valid(res_valid), .res_data(res_data)
    );

    always #4 clk = ~clk;

    function automatic int gf_mul(int a, int b, int m, int p);
        int msk = (1 << m) - 1;
        int full = (p & msk) | (1 << m);
        int x = a & msk;
        int r = 0;
        for (int i = 0; i < 8; i++) begin
            if (((b & msk) >> i) & 1) r ^= x;
            x = x << 1;
            if ((x >> m) & 1) x ^= full;
        end
        return r;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cfg(int m, int p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_m = 4'(m); cfg_poly = 8'(p);
        @(negedge clk);
        cfg_we = 1'b0;
        if (m >= 1 && m <= 8) begin cur_m = m; cur_p = p; end
    endtask

    // mode: 0 plain, 1 cfg write mid-vector, 2 cfg write during reduction
    task automatic run_vec(int n, int mode, bit bubbles, string req);
        int exp = 0;
        int k = 0;
        int nlat = (15 - cur_m + DIGIT - 1) / DIGIT;
        int held;
        for (int i = 0; i < n; i++) exp ^= gf_mul(va[i], vb[i], cur_m, cur_p);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (bubbles && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            check("R2 ready while receiving", int'(in_ready), 1);
            in_valid = 1'b1; in_a = va[i]; in_b = vb[i]; in_last = (i == n-1);
            if (mode == 1 && i == 1) begin
                cfg_we = 1'b1; cfg_m = 4'd3; cfg_poly = 8'h03;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; cfg_we = 1'b0;
        in_a = $urandom; in_b = $urandom;
        if (mode == 2) begin cfg_we = 1'b1; cfg_m = 4'd2; cfg_poly = 8'h03; end
        while (!res_valid && k < 40) begin
            check("R7 ready low in reduction", int'(in_ready), 0);
            @(negedge clk);
            cfg_we = 1'b0;
            k++;
        end
        check("R7 latency", k, nlat);
        check("R7 ready back with result", int'(in_ready), 1);
        check(req, int'(res_data), exp);
        check("R8 upper bits zero", int'(res_data) >> cur_m, 0);
        held = res_data;
        @(negedge clk);
        check("R7 single-cycle done", int'(res_valid), 0);
        check("R8 result held", int'(res_data), held);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready after reset", int'(in_ready), 1);
        check("R1 res_valid after reset", int'(res_valid), 0);
        check("R1 res_data after reset", int'(res_data), 0);
        rst_n = 1'b1;
        // R1 default config: x * x^7 = x^8 = 1D
        va[0] = 8'h02; vb[0] = 8'h80;
        run_vec(1, 0, 0, "R1 default field");
        check("R1 default poly value", int'(res_data), 8'h1D);

        // R3 single pair equals field multiply
        do_cfg(8, 8'h1B);
        va[0] = 8'h53; vb[0] = 8'hCA;
        run_vec(1, 0, 0, "R3 single multiply");

        // R4 junk above m in operands, R5 junk above m in poly
        do_cfg(4, 8'hF3);
        va[0] = 8'hF3; vb[0] = 8'h52;
        va[1] = 8'hAF; vb[1] = 8'h9E;
        run_vec(2, 0, 0, "R4 R5 masked inputs");

        // R6 write mid-vector ignored
        do_cfg(5, 8'h05);
        for (int i = 0; i < 3; i++) begin va[i] = $urandom; vb[i] = $urandom; end
        run_vec(3, 1, 0, "R6 mid-vector write ignored");
        // R6 write during reduction ignored; next vector still uses m=5
        for (int i = 0; i < 2; i++) begin va[i] = $urandom; vb[i] = $urandom; end
        run_vec(2, 2, 0, "R6 reduction write ignored");
        va[0] = 8'h1F; vb[0] = 8'h1F;
        run_vec(1, 0, 0, "R6 config kept after reduction write");
        // R6 out-of-range m ignored
        do_cfg(9, 8'h11);
        do_cfg(0, 8'h11);
        va[0] = 8'h1F; vb[0] = 8'h13;
        run_vec(1, 0, 0, "R6 bad m ignored");

        // R9 consecutive vectors independent; m=1 edge
        do_cfg(1, 8'hFF);
        va[0] = 8'hFF; vb[0] = 8'hFF; va[1] = 8'h01; vb[1] = 8'h01;
        run_vec(2, 0, 0, "R9 m=1 field");
        va[0] = 8'h01; vb[0] = 8'h01;
        run_vec(1, 0, 0, "R9 fresh accumulator");

        // R2 random vectors across all m with bubbles
        for (int t = 0; t < 40; t++) begin
            int n = 1 + ($urandom % 6);
            do_cfg(1 + ($urandom % 8), $urandom);
            for (int i = 0; i < n; i++) begin va[i] = $urandom; vb[i] = $urandom; end
            run_vec(n, 0, 1, "R2 random inner product");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule